// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block lets a host processor read and program the control registers of an on-chip clock controller over a two-wire serial bus. The bus pins are open-drain. SCL and SDA come in as plain inputs and are sampled by a much faster system clock. The slave pulls SDA low through a single drive-enable output. It holds twenty-two eight-bit registers and presents them in parallel to the rest of the controller. Several fields are owned by hardware rather than software: the frequency-select straps captured at power-up, the running watchdog down-count and the watchdog expiry flag. These are merged into the read data whenever the host reads those registers.

A transfer starts with a START condition and the 7-bit device address 69h (write byte D2h, read byte D3h). The first byte after a write address is a command. When its top bit is set, the access is a single-byte access to the register whose index is in the lower seven bits. When its top bit is clear, the access is a block access, which always begins at register 0. The host is expected to send 00h as the command for a block access. A block write carries a byte count, which is acknowledged and not used, followed by data for consecutive registers. A block read returns the count 22 first and then the registers in ascending order. Reads use a repeated START after the command.

Top module: `twi_cfg_slave`

## Requirements
- R1: After reset, every register holds its default and SDA is released. The defaults for indices 0 to 21 are 10h, E2h, FFh, FFh, BFh, 02h, 50h, 70h, 90h, 7Ah, BBh, 0Bh, FBh, 0Fh, 0Ah, 2Ch, 24h, 00h, 00h, D2h, 08h and 00h.
- R2: The slave acknowledges an address byte only when its upper seven bits equal 69h. For any other address it leaves SDA released, and it does not acknowledge or store any further byte until the next START.
- R3: A command byte with bit 7 set selects byte mode with register index = bits 6..0. Each following data byte is acknowledged and written, first to that index and then to the next indices in turn.
- R4: A read address given after a byte-mode command returns the register at the commanded index. The byte is driven MSB first, with SDA changed only while SCL is low.
- R5: A command byte with bit 7 clear selects block mode starting at register 0. In a block write the next byte is a count that is acknowledged and ignored, and the bytes after it go to registers 0, 1, 2 and so on.
- R6: A read after a block-mode command first returns 16h (22) and then the registers from index 0 upward, for as long as the host acknowledges.
- R7: Registers 6 and 7 are read-only and always read 50h and 70h.
- R8: Register 1 bits 4..0 read back the strap input. Writes to register 1 change only bits 7..5.
- R9: Register 20 bits 6..0 read back the live watchdog count while the watchdog-running input is high. Otherwise they read back the stored value. Register 5 bit 5 is read-only and reads back the watchdog-expired input.
- R10: Indices above 21 are acknowledged. Writes to them change no register, and reads from them return 00h.
- R11: A STOP (SDA rising while SCL is high) returns the slave to idle with SDA released. Bytes clocked after a STOP and before the next START are not acknowledged. A START (SDA falling while SCL is high) always restarts address reception.
- R12: The slave changes its SDA drive only while SCL is low. It releases SDA at the end of each acknowledge slot, and after a read byte that the host does not acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock pin level |
| sda_i | input | 1 | Serial data pin level |
| sda_drive_low_o | output | 1 | High pulls SDA low |
| strap_fs_i | input | 5 | Frequency-select straps latched at power-up |
| wd_running_i | input | 1 | Watchdog is counting down |
| wd_expired_i | input | 1 | Watchdog has reached zero |
| wd_count_i | input | 7 | Present watchdog down-count |
| regs_o | output | 176 | Stored register contents, register n in bits 8n+7..8n |

## Verification
The assertions assume a well-behaved host. It changes SDA only while SCL is low, except when it forms a START or STOP. It never forms a START or STOP while the slave is holding SDA low. SCL phases are long enough to pass through the synchronizer. The bench's bit-level tasks keep to these rules by construction. Each SCL phase lasts ten system clocks, data is set up a full phase before SCL rises, and STOP is issued only after a NACK or after the slave has released the line. The hardware status inputs are changed only between transfers.

// File: rtl/twi_pkg.sv
package twi_pkg;

  localparam int unsigned NREG      = 22;
  localparam int unsigned IDX_STRAP = 1;
  localparam int unsigned IDX_WDCTL = 5;
  localparam int unsigned IDX_RSV   = 6;
  localparam int unsigned IDX_ID    = 7;
  localparam int unsigned IDX_WDCNT = 20;
  localparam int unsigned WDEXP_BIT = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_CNT,
    ST_WDATA,
    ST_RDATA,
    ST_SKIP
  } twi_state_e;

  // power-up value of each register
  function automatic logic [7:0] reg_default(input int unsigned idx);
    case (idx)
      0:  return 8'h10;
      1:  return 8'hE2;
      2:  return 8'hFF;
      3:  return 8'hFF;
      4:  return 8'hBF;
      5:  return 8'h02;
      6:  return 8'h50;
      7:  return 8'h70;
      8:  return 8'h90;
      9:  return 8'h7A;
      10: return 8'hBB;
      11: return 8'h0B;
      12: return 8'hFB;
      13: return 8'h0F;
      14: return 8'h0A;
      15: return 8'h2C;
      16: return 8'h24;
      19: return 8'hD2;
      20: return 8'h08;
      default: return 8'h00;
    endcase
  endfunction

  // bits the host may change
  function automatic logic [7:0] reg_wmask(input int unsigned idx);
    if (idx == IDX_STRAP) return 8'hE0;
    if (idx == IDX_WDCTL) return ~(8'h01 << WDEXP_BIT);
    if (idx == IDX_RSV || idx == IDX_ID) return 8'h00;
    return 8'hFF;
  endfunction

  // register pointer advance, held at the top value
  function automatic logic [7:0] ptr_next(input logic [7:0] p);
    return (p == 8'hFF) ? p : p + 8'd1;
  endfunction

  // masked merge of new data into a register
  function automatic logic [7:0] merge_bits(input logic [7:0] old_v,
                                            input logic [7:0] new_v,
                                            input logic [7:0] msk);
    return (old_v & ~msk) | (new_v & msk);
  endfunction

endpackage

// File: rtl/twi_pin_sync.sv
module twi_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [STAGES-1:0] scl_sh, sda_sh;
  logic              scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_d  <= scl_sh[STAGES-1];
      sda_d  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s    = scl_sh[STAGES-1];
  assign sda_s    = sda_sh[STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/twi_regfile.sv
module twi_regfile
  import twi_pkg::*;
#(
  parameter int unsigned NUM_REGS = 22,
  parameter int unsigned STRAP_W  = 5,
  parameter int unsigned CNT_W    = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [7:0]            wr_idx,
  input  logic [7:0]            wr_data,
  input  logic [7:0]            rd_idx,
  input  logic [STRAP_W-1:0]    strap_i,
  input  logic                  wd_run_i,
  input  logic                  wd_exp_i,
  input  logic [CNT_W-1:0]      wd_cnt_i,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] regs_flat
);

  logic [7:0] regs_w [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [7:0] DFLT = reg_default(g);
    localparam logic [7:0] MASK = reg_wmask(g);
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= DFLT;
      else if (wr_en && wr_idx == 8'(g))
        q <= merge_bits(q, wr_data, MASK);
    end
    assign regs_w[g]            = q;
    assign regs_flat[g*8 +: 8]  = q;
  end

  // read view: stored bits with hardware-owned fields laid over them
  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_idx == 8'(i)) rd_data = regs_w[i];
    if (rd_idx == 8'(IDX_STRAP)) rd_data[STRAP_W-1:0] = strap_i;
    if (rd_idx == 8'(IDX_WDCTL)) rd_data[WDEXP_BIT]   = wd_exp_i;
    if (rd_idx == 8'(IDX_WDCNT) && wd_run_i) rd_data[CNT_W-1:0] = wd_cnt_i;
  end

endmodule

// File: rtl/twi_slave_fsm.sv
module twi_slave_fsm
  import twi_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h69,
  parameter int unsigned NUM_REGS = 22
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic [7:0] rd_data,
  output logic       sda_low,
  output logic       wr_en,
  output logic [7:0] wr_idx,
  output logic [7:0] wr_data,
  output logic [7:0] rd_idx,
  output twi_state_e state_o
);

  localparam logic [7:0] BLK_COUNT = 8'(NUM_REGS);

  twi_state_e st_q;
  logic [3:0] bit_q;
  logic [7:0] sh_q, ptr_q;
  logic [6:0] tx_q;
  logic       blk_q, cnt_pend_q, mack_q, drv_q;
  logic       active, ack_fall, end_fall, addr_hit;
  logic [7:0] load_byte;

  assign active    = (st_q != ST_IDLE) && (st_q != ST_SKIP);
  assign ack_fall  = active && scl_fall && (bit_q == 4'd8);
  assign end_fall  = active && scl_fall && (bit_q == 4'd9);
  assign addr_hit  = (sh_q[7:1] == DEV_ADDR);
  assign load_byte = cnt_pend_q ? BLK_COUNT : rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      bit_q      <= '0;
      sh_q       <= '0;
      tx_q       <= '0;
      ptr_q      <= '0;
      blk_q      <= 1'b0;
      cnt_pend_q <= 1'b0;
      mack_q     <= 1'b0;
      drv_q      <= 1'b0;
    end else if (start_ev) begin
      st_q  <= ST_ADDR;
      bit_q <= '0;
      drv_q <= 1'b0;
    end else if (stop_ev) begin
      st_q  <= ST_IDLE;
      bit_q <= '0;
      drv_q <= 1'b0;
    end else if (active) begin
      if (scl_rise) begin
        if (bit_q < 4'd8) sh_q   <= {sh_q[6:0], sda_s};
        else              mack_q <= ~sda_s;
        if (bit_q < 4'd9) bit_q  <= bit_q + 4'd1;
      end else if (ack_fall) begin
        unique case (st_q)
          ST_ADDR: begin
            if (addr_hit) begin
              drv_q      <= 1'b1;
              st_q       <= sh_q[0] ? ST_RDATA : ST_CMD;
              cnt_pend_q <= blk_q & sh_q[0];
            end else begin
              drv_q <= 1'b0;
              st_q  <= ST_SKIP;
            end
          end
          ST_CMD: begin
            drv_q <= 1'b1;
            blk_q <= ~sh_q[7];
            ptr_q <= sh_q[7] ? {1'b0, sh_q[6:0]} : 8'h00;
            st_q  <= sh_q[7] ? ST_WDATA : ST_CNT;
          end
          ST_CNT: begin
            drv_q <= 1'b1;
            st_q  <= ST_WDATA;
          end
          ST_WDATA: begin
            drv_q <= 1'b1;
            ptr_q <= ptr_next(ptr_q);
          end
          default: drv_q <= 1'b0;  // read byte done: host owns the ack slot
        endcase
      end else if (end_fall) begin
        bit_q <= '0;
        if (st_q == ST_RDATA && mack_q) begin
          tx_q  <= load_byte[6:0];
          drv_q <= ~load_byte[7];
          if (cnt_pend_q) cnt_pend_q <= 1'b0;
          else            ptr_q      <= ptr_next(ptr_q);
        end else begin
          drv_q <= 1'b0;
          if (st_q == ST_RDATA) st_q <= ST_SKIP;
        end
      end else if (scl_fall && st_q == ST_RDATA && bit_q != 4'd0) begin
        drv_q <= ~tx_q[6];
        tx_q  <= {tx_q[5:0], 1'b0};
      end
    end
  end

  assign sda_low = drv_q;
  assign wr_en   = ack_fall && (st_q == ST_WDATA);
  assign wr_idx  = ptr_q;
  assign wr_data = sh_q;
  assign rd_idx  = ptr_q;
  assign state_o = st_q;

endmodule

// File: rtl/twi_cfg_slave.sv
module twi_cfg_slave
  import twi_pkg::*;
#(
  parameter int unsigned NUM_REGS    = NREG,
  parameter logic [6:0]  DEV_ADDR    = 7'h69,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned STRAP_W     = 5,
  parameter int unsigned WD_CNT_W    = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_drive_low_o,
  input  logic [STRAP_W-1:0]    strap_fs_i,
  input  logic                  wd_running_i,
  input  logic                  wd_expired_i,
  input  logic [WD_CNT_W-1:0]   wd_count_i,
  output logic [NUM_REGS*8-1:0] regs_o
);

  // internal events, named for the bound checker
  logic       scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic       wr_en;
  logic [7:0] wr_idx, wr_data, rd_idx, rd_data;
  twi_state_e fsm_state;

  twi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  twi_slave_fsm #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .rd_data  (rd_data),
    .sda_low  (sda_drive_low_o),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .rd_idx   (rd_idx),
    .state_o  (fsm_state)
  );

  twi_regfile #(.NUM_REGS(NUM_REGS), .STRAP_W(STRAP_W), .CNT_W(WD_CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .rd_idx    (rd_idx),
    .strap_i   (strap_fs_i),
    .wd_run_i  (wd_running_i),
    .wd_exp_i  (wd_expired_i),
    .wd_cnt_i  (wd_count_i),
    .rd_data   (rd_data),
    .regs_flat (regs_o)
  );

endmodule

// File: rtl/twi_cfg_slave_chk.sv
module twi_cfg_slave_chk
  import twi_pkg::*;
#(
  parameter int unsigned NUM_REGS = NREG
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_s,
  input logic                  start_ev,
  input logic                  stop_ev,
  input logic                  sda_low,
  input logic                  wr_en,
  input logic [7:0]            wr_idx,
  input twi_state_e            state,
  input logic [NUM_REGS*8-1:0] regs
);

  // R12
  sda_quiet_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s) && !start_ev && !stop_ev && !$past(start_ev) && !$past(stop_ev))
      |-> $stable(sda_low));

  // R3
  write_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> sda_low);

  // R10
  range_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx >= 8'(NUM_REGS)) |=> $stable(regs));

  // R7
  ro_regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_idx == 8'(IDX_RSV) || wr_idx == 8'(IDX_ID)))
      |=> $stable(regs[IDX_RSV*8 +: 16]));

  // R8
  strap_bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 8'(IDX_STRAP)) |=> $stable(regs[IDX_STRAP*8 +: 5]));

  // R11
  start_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (state == ST_ADDR));

  // R11
  stop_idles_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (state == ST_IDLE && !sda_low));

  // R2
  skip_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP || state == ST_IDLE) |-> !sda_low);

endmodule

bind twi_cfg_slave twi_cfg_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_s    (scl_s),
  .start_ev (start_ev),
  .stop_ev  (stop_ev),
  .sda_low  (sda_drive_low_o),
  .wr_en    (wr_en),
  .wr_idx   (wr_idx),
  .state    (fsm_state),
  .regs     (regs_o)
);

// File: tb/test_twi_cfg_slave.sv
module test_twi_cfg_slave;

  localparam int Q = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         m_scl = 1'b1;
  logic         m_sda = 1'b1;
  logic [4:0]   strap = 5'b00010;
  logic         wd_run = 1'b0;
  logic         wd_exp = 1'b0;
  logic [6:0]   wd_cnt = 7'h00;
  logic         sda_low;
  logic [175:0] regs;
  wire          sda_line = m_sda & ~sda_low;

  always #5 clk = ~clk;

  twi_cfg_slave i_twi_cfg_slave (
    .clk             (clk),
    .rst_n           (rst_n),
    .scl_i           (m_scl),
    .sda_i           (sda_line),
    .sda_drive_low_o (sda_low),
    .strap_fs_i      (strap),
    .wd_running_i    (wd_run),
    .wd_expired_i    (wd_exp),
    .wd_count_i      (wd_cnt),
    .regs_o          (regs)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] mdl [22];

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---- model of the register bank, from the requirements ----
  function automatic logic [7:0] wmask(input int idx);
    if (idx == 1) return 8'hE0;
    if (idx == 5) return 8'hDF;
    if (idx == 6 || idx == 7) return 8'h00;
    return 8'hFF;
  endfunction

  task automatic mdl_write(input int idx, input logic [7:0] d);
    if (idx < 22) mdl[idx] = (mdl[idx] & ~wmask(idx)) | (d & wmask(idx));
  endtask

  function automatic logic [7:0] exp_rd(input int idx);
    logic [7:0] v;
    if (idx >= 22) return 8'h00;
    v = mdl[idx];
    if (idx == 1) v[4:0] = strap;
    if (idx == 5) v[5] = wd_exp;
    if (idx == 20 && wd_run) v[6:0] = wd_cnt;
    return v;
  endfunction

  task automatic chk_regs(input string what);
    int bad = 0;
    for (int i = 0; i < 22; i++)
      if (regs[i*8 +: 8] !== mdl[i]) begin
        bad++;
        $display("FAIL %s: reg %0d actual %0h expected %0h", what, i, regs[i*8 +: 8], mdl[i]);
      end
    n_chk++;
    if (bad != 0) n_bad++;
  endtask

  // ---- bus primitives ----
  task automatic bus_start();
    m_sda = 1'b1; waitc(Q);
    m_scl = 1'b1; waitc(Q);
    m_sda = 1'b0; waitc(Q);
    m_scl = 1'b0; waitc(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; waitc(Q);
    m_scl = 1'b1; waitc(Q);
    m_sda = 1'b1; waitc(Q);
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = d[i]; waitc(Q);
      m_scl = 1'b1; waitc(Q);
      m_scl = 1'b0; waitc(Q);
    end
    m_sda = 1'b1; waitc(Q);
    m_scl = 1'b1; waitc(Q/2);
    ack = (sda_line == 1'b0);
    waitc(Q/2);
    m_scl = 1'b0; waitc(Q);
  endtask

  task automatic rbyte(input logic mack, output logic [7:0] d);
    logic hold;
    int   moved = 0;
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitc(Q);
      m_scl = 1'b1; waitc(Q/2);
      d[i] = sda_line;
      hold = sda_low;
      waitc(Q/2);
      if (sda_low !== hold) moved++;
      m_scl = 1'b0;
    end
    chk("R12 drive stable while SCL high", moved, 0);
    waitc(Q/2);
    m_sda = ~mack; waitc(Q);
    m_scl = 1'b1; waitc(Q);
    m_scl = 1'b0; waitc(Q/2);
    m_sda = 1'b1; waitc(Q);
  endtask

  task automatic byte_write(input string tag, input logic [7:0] idx, input logic [7:0] d);
    logic a;
    bus_start();
    wbyte(8'hD2, a); chk({tag, " addr ack"}, a, 1);
    wbyte(8'h80 | idx, a); chk({tag, " cmd ack"}, a, 1);
    wbyte(d, a); chk({tag, " data ack"}, a, 1);
    bus_stop();
    mdl_write(int'(idx), d);
  endtask

  task automatic byte_read(input string tag, input logic [7:0] idx, output logic [7:0] d);
    logic a;
    bus_start();
    wbyte(8'hD2, a); chk({tag, " addr ack"}, a, 1);
    wbyte(8'h80 | idx, a); chk({tag, " cmd ack"}, a, 1);
    bus_start();
    wbyte(8'hD3, a); chk({tag, " read addr ack"}, a, 1);
    rbyte(1'b0, d);
    bus_stop();
    chk({tag, " released after NACK"}, sda_low, 0);
  endtask

  // ---- scenarios ----
  task automatic t_reset();
    chk_regs("R1 defaults");
    chk("R1 SDA released", sda_low, 0);
  endtask

  task automatic t_bad_addr();
    logic a;
    bus_start();
    wbyte(8'hA4, a); chk("R2 foreign address NACK", a, 0);
    wbyte(8'h82, a); chk("R2 later byte NACK", a, 0);
    wbyte(8'h00, a); chk("R2 later byte NACK", a, 0);
    bus_stop();
    chk_regs("R2 no write");
  endtask

  task automatic t_byte_write();
    logic a;
    bus_start();
    wbyte(8'hD2, a); chk("R3 addr ack", a, 1);
    wbyte(8'h83, a); chk("R3 cmd ack", a, 1);
    wbyte(8'h5A, a); chk("R3 data ack", a, 1);
    wbyte(8'h3C, a); chk("R3 next data ack", a, 1);
    bus_stop();
    mdl_write(3, 8'h5A);
    mdl_write(4, 8'h3C);
    chk_regs("R3 consecutive writes");
  endtask

  task automatic t_byte_read();
    logic [7:0] d;
    byte_read("R4", 8'h03, d);  chk("R4 read reg3", d, exp_rd(3));
    byte_read("R4", 8'h04, d);  chk("R4 read reg4", d, exp_rd(4));
    byte_read("R4", 8'h0A, d);  chk("R4 read reg10", d, exp_rd(10));
  endtask

  task automatic t_block_write();
    logic a;
    bus_start();
    wbyte(8'hD2, a); chk("R5 addr ack", a, 1);
    wbyte(8'h00, a); chk("R5 cmd ack", a, 1);
    wbyte(8'h03, a); chk("R5 count ack", a, 1);
    wbyte(8'h11, a); chk("R5 data0 ack", a, 1);
    wbyte(8'h22, a); chk("R5 data1 ack", a, 1);
    wbyte(8'h33, a); chk("R5 data2 ack", a, 1);
    bus_stop();
    mdl_write(0, 8'h11);
    mdl_write(1, 8'h22);
    mdl_write(2, 8'h33);
    chk_regs("R5 R8 block write");
  endtask

  task automatic t_block_read();
    logic a;
    logic [7:0] d;
    int bad = 0;
    strap  = 5'b10101;
    wd_exp = 1'b1;
    waitc(4);
    bus_start();
    wbyte(8'hD2, a); chk("R6 addr ack", a, 1);
    wbyte(8'h00, a); chk("R6 cmd ack", a, 1);
    bus_start();
    wbyte(8'hD3, a); chk("R6 read addr ack", a, 1);
    rbyte(1'b1, d);  chk("R6 count byte", d, 8'h16);
    for (int i = 0; i < 22; i++) begin
      rbyte(i != 21, d);
      if (d !== exp_rd(i)) begin
        bad++;
        $display("FAIL R6 block read reg %0d: actual %0h expected %0h", i, d, exp_rd(i));
      end
      if (i == 1) chk("R8 strap readback", d, {3'b001, 5'b10101});
      if (i == 5) chk("R9 expired flag readback", d[5], 1);
      if (i == 6) chk("R7 reg6 read", d, 8'h50);
      if (i == 7) chk("R7 reg7 read", d, 8'h70);
    end
    n_chk++;
    if (bad != 0) n_bad++;
    bus_stop();
    chk("R12 released after last byte", sda_low, 0);
  endtask

  task automatic t_read_only();
    logic [7:0] d;
    byte_write("R7", 8'h06, 8'h00);
    byte_write("R7", 8'h07, 8'hFF);
    byte_write("R8", 8'h01, 8'h1F);
    byte_write("R9", 8'h05, 8'hFF);
    chk_regs("R7 R8 R9 masked writes");
    byte_read("R7", 8'h06, d); chk("R7 reg6 after write", d, 8'h50);
    byte_read("R7", 8'h07, d); chk("R7 reg7 after write", d, 8'h70);
    byte_read("R8", 8'h01, d); chk("R8 reg1 after write", d, exp_rd(1));
    wd_exp = 1'b0;
    waitc(4);
    byte_read("R9", 8'h05, d); chk("R9 expired flag clear", d, exp_rd(5));
  endtask

  task automatic t_live_count();
    logic [7:0] d;
    byte_write("R9", 8'h14, 8'h8F);
    wd_run = 1'b1;
    wd_cnt = 7'h2B;
    waitc(4);
    byte_read("R9", 8'h14, d); chk("R9 live count", d, 8'hAB);
    wd_run = 1'b0;
    waitc(4);
    byte_read("R9", 8'h14, d); chk("R9 stored count", d, 8'h8F);
  endtask

  task automatic t_out_of_range();
    logic a;
    logic [7:0] d;
    byte_write("R10", 8'h1E, 8'h77);
    chk_regs("R10 write dropped");
    byte_read("R10", 8'h1E, d); chk("R10 read past end", d, 8'h00);
    byte_write("R10", 8'h15, 8'hC3);
    bus_start();
    wbyte(8'hD2, a); chk("R10 addr ack", a, 1);
    wbyte(8'h95, a); chk("R10 cmd ack", a, 1);
    bus_start();
    wbyte(8'hD3, a); chk("R10 read addr ack", a, 1);
    rbyte(1'b1, d); chk("R10 last reg", d, 8'hC3);
    rbyte(1'b0, d); chk("R10 beyond last reg", d, 8'h00);
    bus_stop();
  endtask

  task automatic t_stop_idle();
    logic a;
    bus_start();
    wbyte(8'hD2, a); chk("R11 addr ack", a, 1);
    bus_stop();
    chk("R11 released at stop", sda_low, 0);
    wbyte(8'hD2, a); chk("R11 no ack without START", a, 0);
    wbyte(8'h81, a); chk("R11 no ack without START", a, 0);
    bus_stop();
    chk_regs("R11 no write while idle");
    byte_write("R11", 8'h10, 8'h99);
    chk_regs("R11 START restarts");
  endtask

  initial begin
    mdl = '{8'h10, 8'hE2, 8'hFF, 8'hFF, 8'hBF, 8'h02, 8'h50, 8'h70, 8'h90, 8'h7A, 8'hBB,
            8'h0B, 8'hFB, 8'h0F, 8'h0A, 8'h2C, 8'h24, 8'h00, 8'h00, 8'hD2, 8'h08, 8'h00};
    waitc(5);
    rst_n = 1'b1;
    waitc(5);
    t_reset();
    t_bad_addr();
    t_byte_write();
    t_byte_read();
    t_block_write();
    t_block_read();
    t_read_only();
    t_live_count();
    t_out_of_range();
    t_stop_idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule